// File: doc/BRIEF.md
# Power Sequencing and Watchdog Controller

This block owns the supply-enable, CPU reset, clock-out gating and serial-disable outputs of a battery-backed timekeeper. Software asks for a power-down by pulsing a request. The block then drops supply-enable, gates the clock output, pulls the CPU reset low and blocks the serial port. It stays in that state until the system-voltage-good input rises, or until an enabled interrupt source fires while system voltage is present. Both wake paths release the reset and raise supply-enable in the same cycle.

The block also holds the interrupt logic that can wake it. There are three sources, all merged onto one active-low interrupt line:
- an alarm comparator that checks seconds, minutes and hours on every time update;
- a periodic timer whose period is a power-of-two multiple of a base number of time-base ticks;
- a one-shot power-sense detector on a line-fail input.

A sticky status vector records which sources fired, and a status read clears it.

A watchdog, when enabled, counts time-base ticks. Any change of level on the select line restarts the count, with no transfer needed. If the count expires, the block emits a CPU reset pulse of fixed length. The block has no streaming data path, so every pin is a plain level or one-cycle pulse and there is no back-pressure.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, supply-enable, clock-out enable and CPU reset (active low, so high) are 1, serial-disable is 0, the interrupt output is high and the status vector is 0.
- R2: A power-down request while running makes supply-enable, clock-out enable and CPU reset low and serial-disable high on the next cycle.
- R3: While powered down, the state is held as long as system voltage does not rise and no enabled interrupt event occurs with system voltage high.
- R4: While powered down, a low-to-high change of system voltage returns to running on the next cycle, with supply-enable and CPU reset rising in the same cycle.
- R5: While powered down, an enabled interrupt event wakes the block on the next cycle only if system voltage is high at that time. A source whose enable is low never wakes it.
- R6: On a time-update pulse with the alarm enable high and all three current time fields equal to the alarm fields, status bit 0 is set. If any field differs or the enable is low, bit 0 is not set.
- R7: The interrupt output is low exactly while any status bit is set. A status read clears all bits on the next cycle, but a source event in the same cycle as the read still sets its bit.
- R8: With the periodic enable high, status bit 1 is set on every (PER_BASE << sel)-th tick counted from the enable. Clearing the enable restarts the count.
- R9: The power-sense detector is armed by a rising edge of its enable. A rising line-fail input while armed sets status bit 2 and disarms it. A further event needs the enable written low and then high again.
- R10: With the watchdog enabled, any change of the select-line level restarts the count, and no reset is issued while changes keep arriving within the limit.
- R11: With the watchdog enabled and running, WD_LIMIT ticks without a select-line change drive CPU reset low for WD_RST_LEN cycles. With it disabled, no reset is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Software power-down request pulse |
| vsys_i | input | 1 | System voltage present |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| time_upd_i | input | 1 | Current time fields were updated |
| now_sec_i | input | TIME_W | Current seconds (BCD) |
| now_min_i | input | TIME_W | Current minutes (BCD) |
| now_hr_i | input | TIME_W | Current hours (BCD) |
| alm_sec_i | input | TIME_W | Alarm seconds |
| alm_min_i | input | TIME_W | Alarm minutes |
| alm_hr_i | input | TIME_W | Alarm hours |
| alarm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| per_sel_i | input | PER_SEL_W | Periodic period select (base shifted left) |
| psense_en_i | input | 1 | Power-sense enable, rising edge arms |
| line_fail_i | input | 1 | Line-fail indication |
| wdog_en_i | input | 1 | Watchdog enable |
| ss_i | input | 1 | Select line, level changes kick the watchdog |
| stat_rd_i | input | 1 | Status read pulse, clears status |
| stat_o | output | 3 | Sticky sources: bit0 alarm, bit1 periodic, bit2 power sense |
| irq_n_o | output | 1 | Active-low interrupt |
| pse_o | output | 1 | Supply enable |
| clkout_en_o | output | 1 | Clock output enable |
| cpu_rst_n_o | output | 1 | Active-low CPU reset |
| ser_dis_o | output | 1 | Serial interface disable |

## Verification
The wake logic is tried with a steady-high and a steady-low system voltage, a rising voltage, and interrupt events from enabled and disabled sources. This separates an edge-sensitive wake from a level-sensitive one and shows that the enable gating works. The alarm is hit with random time triples in which each field matches or misses independently, so a comparator that ignores one field is exposed. Periodic timing is measured at two select values to catch a wrong shift. The power-sense re-arm and the watchdog's exact tick count and pulse length are driven by directed sequences.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic {PS_RUN = 1'b0, PS_DOWN = 1'b1} pwr_state_e;
  localparam int SRC_ALARM  = 0;
  localparam int SRC_PERIOD = 1;
  localparam int SRC_PSENSE = 2;
  localparam int SRC_NUM    = 3;
  localparam int FIELD_NUM  = 3;
  typedef logic [SRC_NUM-1:0] src_vec_t;
endpackage

// File: rtl/pwrseq_alarm_cmp.sv
module pwrseq_alarm_cmp
  import pwrseq_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic [FIELD_NUM-1:0][TIME_W-1:0] now_i,
  input  logic [FIELD_NUM-1:0][TIME_W-1:0] alm_i,
  input  logic                             en_i,
  input  logic                             upd_i,
  output logic                             hit_o
);
  logic [FIELD_NUM-1:0] field_eq;

  for (genvar f = 0; f < FIELD_NUM; f++) begin : g_field
    assign field_eq[f] = (now_i[f] == alm_i[f]);
  end

  assign hit_o = en_i && upd_i && (&field_eq);
endmodule

// File: rtl/pwrseq_periodic.sv
module pwrseq_periodic #(
  parameter int BASE  = 256,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  output logic             evt_o
);
  localparam int MAXP = BASE << ((1 << SEL_W) - 1);
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          wrap;

  always_comb begin
    last = (CW'(BASE) << sel_i) - CW'(1);
  end

  assign wrap  = (cnt_q >= last);
  assign evt_o = en_i && tick_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pwrseq_watchdog.sv
module pwrseq_watchdog #(
  parameter int LIMIT   = 1024,
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic ss_i,
  output logic rst_req_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam int RW = $clog2(RST_LEN + 1);

  logic          ss_q;
  logic          kick;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rcnt_q;
  logic          expire;

  assign kick   = ss_i ^ ss_q;
  assign expire = en_i && !kick && tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b0;
    else        ss_q <= ss_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || kick || expire) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
    end else if (!en_i) begin
      rcnt_q <= '0;
    end else if (expire) begin
      rcnt_q <= RW'(RST_LEN);
    end else if (rcnt_q != '0) begin
      rcnt_q <= rcnt_q - RW'(1);
    end
  end

  assign rst_req_o = (rcnt_q != '0);
endmodule

// File: rtl/pwrseq_irq.sv
module pwrseq_irq
  import pwrseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     alm_evt_i,
  input  logic     per_evt_i,
  input  logic     line_fail_i,
  input  logic     ps_en_i,
  input  logic     rd_i,
  output logic     evt_any_o,
  output src_vec_t stat_o
);
  logic     line_q;
  logic     pen_q;
  logic     armed_q;
  logic     ps_evt;
  src_vec_t evt;
  src_vec_t stat_q;

  assign ps_evt = ps_en_i && armed_q && line_fail_i && !line_q;

  always_comb begin
    evt             = '0;
    evt[SRC_ALARM]  = alm_evt_i;
    evt[SRC_PERIOD] = per_evt_i;
    evt[SRC_PSENSE] = ps_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      pen_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      line_q <= line_fail_i;
      pen_q  <= ps_en_i;
      if (!ps_en_i)    armed_q <= 1'b0;
      else if (!pen_q) armed_q <= 1'b1;
      else if (ps_evt) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (rd_i ? src_vec_t'(0) : stat_q) | evt;
  end

  assign evt_any_o = |evt;
  assign stat_o    = stat_q;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int TIME_W     = 8,
  parameter int PER_BASE   = 256,
  parameter int PER_SEL_W  = 2,
  parameter int WD_LIMIT   = 1024,
  parameter int WD_RST_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_req_i,
  input  logic                 vsys_i,
  input  logic                 tick_i,
  input  logic                 time_upd_i,
  input  logic [TIME_W-1:0]    now_sec_i,
  input  logic [TIME_W-1:0]    now_min_i,
  input  logic [TIME_W-1:0]    now_hr_i,
  input  logic [TIME_W-1:0]    alm_sec_i,
  input  logic [TIME_W-1:0]    alm_min_i,
  input  logic [TIME_W-1:0]    alm_hr_i,
  input  logic                 alarm_en_i,
  input  logic                 per_en_i,
  input  logic [PER_SEL_W-1:0] per_sel_i,
  input  logic                 psense_en_i,
  input  logic                 line_fail_i,
  input  logic                 wdog_en_i,
  input  logic                 ss_i,
  input  logic                 stat_rd_i,
  output logic [2:0]           stat_o,
  output logic                 irq_n_o,
  output logic                 pse_o,
  output logic                 clkout_en_o,
  output logic                 cpu_rst_n_o,
  output logic                 ser_dis_o
);
  pwr_state_e state_q;
  logic       vsys_q;
  logic       vsys_rise;
  logic       alm_hit;
  logic       per_evt;
  logic       evt_any;
  logic       wd_rst;
  logic       running;
  logic       wake;
  src_vec_t   stat;

  logic [FIELD_NUM-1:0][TIME_W-1:0] now_f;
  logic [FIELD_NUM-1:0][TIME_W-1:0] alm_f;

  assign now_f = {now_hr_i, now_min_i, now_sec_i};
  assign alm_f = {alm_hr_i, alm_min_i, alm_sec_i};

  pwrseq_alarm_cmp #(.TIME_W(TIME_W)) u_alarm (
    .now_i (now_f),
    .alm_i (alm_f),
    .en_i  (alarm_en_i),
    .upd_i (time_upd_i),
    .hit_o (alm_hit)
  );

  pwrseq_periodic #(.BASE(PER_BASE), .SEL_W(PER_SEL_W)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (per_en_i),
    .sel_i  (per_sel_i),
    .tick_i (tick_i),
    .evt_o  (per_evt)
  );

  pwrseq_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .alm_evt_i   (alm_hit),
    .per_evt_i   (per_evt),
    .line_fail_i (line_fail_i),
    .ps_en_i     (psense_en_i),
    .rd_i        (stat_rd_i),
    .evt_any_o   (evt_any),
    .stat_o      (stat)
  );

  assign running = (state_q == PS_RUN);

  pwrseq_watchdog #(.LIMIT(WD_LIMIT), .RST_LEN(WD_RST_LEN)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wdog_en_i && running),
    .tick_i    (tick_i),
    .ss_i      (ss_i),
    .rst_req_o (wd_rst)
  );

  assign vsys_rise = vsys_i && !vsys_q;
  assign wake      = vsys_rise || (evt_any && vsys_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      vsys_q  <= 1'b1;
    end else begin
      vsys_q <= vsys_i;
      case (state_q)
        PS_RUN:  if (pd_req_i) state_q <= PS_DOWN;
        PS_DOWN: if (wake)     state_q <= PS_RUN;
        default:               state_q <= PS_RUN;
      endcase
    end
  end

  assign pse_o       = running;
  assign clkout_en_o = running;
  assign ser_dis_o   = !running;
  assign cpu_rst_n_o = running && !wd_rst;
  assign stat_o      = stat;
  assign irq_n_o     = !(|stat);
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_req_i,
  input logic       vsys_i,
  input logic       tick_i,
  input logic       time_upd_i,
  input logic       alarm_en_i,
  input logic       line_fail_i,
  input logic       wdog_en_i,
  input logic       stat_rd_i,
  input logic [2:0] stat_o,
  input logic       irq_n_o,
  input logic       pse_o,
  input logic       cpu_rst_n_o
);
  // R2
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pse_o) |-> $past(pd_req_i));

  // R4
  wake_vsys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pse_o) |-> $past(vsys_i));

  // R4
  wake_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pse_o) |-> cpu_rst_n_o);

  // R6
  alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> $past(alarm_en_i && time_upd_i));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !time_upd_i && !tick_i && !line_fail_i) |=> irq_n_o);

  // R11
  wd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_rst_n_o) && pse_o) |-> $past(wdog_en_i));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pd_req_i    (pd_req_i),
  .vsys_i      (vsys_i),
  .tick_i      (tick_i),
  .time_upd_i  (time_upd_i),
  .alarm_en_i  (alarm_en_i),
  .line_fail_i (line_fail_i),
  .wdog_en_i   (wdog_en_i),
  .stat_rd_i   (stat_rd_i),
  .stat_o      (stat_o),
  .irq_n_o     (irq_n_o),
  .pse_o       (pse_o),
  .cpu_rst_n_o (cpu_rst_n_o)
);

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
  localparam int TW     = 8;
  localparam int PBASE  = 3;
  localparam int SELW   = 2;
  localparam int WDLIM  = 6;
  localparam int WDLEN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, vsys = 1, tick = 0, tupd = 0;
  logic [TW-1:0] nsec = 0, nmin = 0, nhr = 0;
  logic [TW-1:0] asec = 8'h30, amin = 8'h15, ahr = 8'h07;
  logic alm_en = 0, per_en = 0, ps_en = 0, line = 0, wd_en = 0, ss = 0, srd = 0;
  logic [SELW-1:0] psel = 0;
  logic [2:0] stat;
  logic irq_n, pse, clke, crst_n, sdis;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwrseq_ctrl #(.TIME_W(TW), .PER_BASE(PBASE), .PER_SEL_W(SELW),
                .WD_LIMIT(WDLIM), .WD_RST_LEN(WDLEN)) u_pwrseq_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req), .vsys_i(vsys), .tick_i(tick),
    .time_upd_i(tupd), .now_sec_i(nsec), .now_min_i(nmin), .now_hr_i(nhr),
    .alm_sec_i(asec), .alm_min_i(amin), .alm_hr_i(ahr), .alarm_en_i(alm_en),
    .per_en_i(per_en), .per_sel_i(psel), .psense_en_i(ps_en),
    .line_fail_i(line), .wdog_en_i(wd_en), .ss_i(ss), .stat_rd_i(srd),
    .stat_o(stat), .irq_n_o(irq_n), .pse_o(pse), .clkout_en_o(clke),
    .cpu_rst_n_o(crst_n), .ser_dis_o(sdis)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic bit alarm_expect(input bit en, input logic [TW-1:0] s,
                                      input logic [TW-1:0] m, input logic [TW-1:0] h);
    return en && (s == asec) && (m == amin) && (h == ahr);
  endfunction

  function automatic int pwr_vec();
    return {28'd0, pse, clke, crst_n, sdis};
  endfunction

  task automatic clear_stat();
    srd = 1; cyc(); srd = 0;
  endtask

  task automatic alarm_upd(input logic [TW-1:0] s, input logic [TW-1:0] m,
                           input logic [TW-1:0] h);
    nsec = s; nmin = m; nhr = h; tupd = 1; cyc(); tupd = 0;
  endtask

  initial begin
    int rv;
    rv = $urandom(32'h5eed);
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    check("R1 power outputs", pwr_vec(), 4'b1110);
    check("R1 irq", irq_n, 1);
    check("R1 status", stat, 0);

    // R2 power-down entry
    pd_req = 1; cyc(); pd_req = 0;
    check("R2 power-down outputs", pwr_vec(), 4'b0001);
    // R3 hold with steady vsys high
    repeat (5) cyc();
    check("R3 hold vsys steady", pse, 0);
    vsys = 0; cyc();
    check("R3 hold vsys falling", pse, 0);
    // R4 rising vsys wakes
    vsys = 1; cyc();
    check("R4 wake supply", pse, 1);
    check("R4 wake reset release", crst_n, 1);

    // R5 disabled source does not wake, enabled one does with vsys high
    pd_req = 1; cyc(); pd_req = 0;
    alm_en = 0; alarm_upd(asec, amin, ahr);
    check("R5 disabled alarm no wake", pse, 0);
    check("R6 disabled alarm no status", stat, 0);
    alm_en = 1; alarm_upd(asec, amin, ahr);
    check("R5 enabled alarm wakes", pse, 1);
    check("R5 reset released", crst_n, 1);
    check("R6 alarm status bit0", stat, 3'b001);
    check("R7 irq low", irq_n, 0);
    clear_stat();
    check("R7 read clears", stat, 0);
    check("R7 irq released", irq_n, 1);
    // R5 no wake with vsys low
    vsys = 0; cyc();
    pd_req = 1; cyc(); pd_req = 0;
    alarm_upd(asec, amin, ahr);
    check("R5 no wake vsys low", pse, 0);
    check("R6 status while down", stat, 3'b001);
    vsys = 1; cyc();
    check("R4 wake after rise", pse, 1);
    // R7 event during read wins
    srd = 1; nsec = asec; tupd = 1; cyc(); srd = 0; tupd = 0;
    check("R7 event beats read", stat, 3'b001);
    clear_stat();

    // R6 random alarm patterns
    for (int i = 0; i < 40; i++) begin
      logic [TW-1:0] s, m, h;
      bit en, exp;
      s = ($urandom % 2) ? asec : TW'($urandom % 60);
      m = ($urandom % 2) ? amin : TW'($urandom % 60);
      h = ($urandom % 2) ? ahr  : TW'($urandom % 24);
      en = ($urandom % 4) != 0;
      alm_en = en;
      exp = alarm_expect(en, s, m, h);
      alarm_upd(s, m, h);
      check("R6 random alarm", stat[0], exp);
      clear_stat();
    end
    alm_en = 0;

    // R8 periodic, sel 0 then sel 2
    for (int k = 0; k < 2; k++) begin
      int n;
      psel = (k == 0) ? 2'd0 : 2'd2;
      n = PBASE << psel;
      per_en = 0; cyc(); per_en = 1; cyc();
      tick = 1; repeat (n - 1) cyc();
      check("R8 periodic before period", stat[1], 0);
      cyc(); tick = 0;
      check("R8 periodic at period", stat, 3'b010);
      clear_stat();
    end
    per_en = 0; cyc();

    // R9 power sense arm, disarm, re-arm
    ps_en = 1; cyc();
    line = 1; cyc(); line = 0;
    check("R9 first sense event", stat, 3'b100);
    clear_stat();
    line = 1; cyc(); line = 0; cyc();
    check("R9 disarmed after event", stat, 0);
    ps_en = 0; cyc(); ps_en = 1; cyc();
    line = 1; cyc(); line = 0;
    check("R9 re-armed", stat, 3'b100);
    clear_stat(); ps_en = 0;

    // R11 disabled watchdog never resets
    tick = 1;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (!crst_n) check("R11 disabled no reset", crst_n, 1);
    end
    check("R11 disabled no reset", crst_n, 1);
    // R10 kicked watchdog stays quiet
    wd_en = 1;
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) ss = ~ss;
      cyc();
      if (!crst_n) check("R10 kicked no reset", crst_n, 1);
    end
    check("R10 kicked no reset", crst_n, 1);
    // R11 timeout after exactly WD_LIMIT ticks, pulse WD_RST_LEN cycles
    ss = ~ss; cyc();
    begin
      int n = 0;
      int low = 1;
      do begin cyc(); n++; end while (crst_n && n < 50);
      check("R11 ticks to timeout", n, WDLIM);
      tick = 0;
      while (!crst_n && low < 50) begin cyc(); if (!crst_n) low++; end
      check("R11 reset pulse length", low, WDLEN);
      check("R11 supply kept", pse, 1);
    end
    wd_en = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule